// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the serial slave side of a NOR flash model. It runs on a fast system clock and oversamples the four serial pins. It samples the data input on each rising serial clock edge and launches output bits on each falling edge, most significant bit first. The first byte of every chip-select frame is decoded as an opcode. Address, dummy and payload bytes are collected as they arrive. For the read-type opcodes the block generates the output stream itself: array data from a small internal byte array, the status byte supplied by the controller, or the two identification codes. For every other known opcode it passes the opcode and all later bytes to a separate execution controller, which also loads the byte array through a write port.

At each chip-select fall the block records whether the serial clock was idle low (mode 0) or idle high (mode 3). A hold pin pauses the serial exchange without ending the frame. Raising chip select always abandons whatever is in progress.

Top module: `spi_flash_front`

## Requirements
- R1: After reset `spi_so_oe` is 0, `mode3` is 0, and neither `cmd_stb` nor `rx_stb` has pulsed.
- R2: Input bits are taken on rising SCK edges and output bits change on falling SCK edges, MSB first. `spi_so_oe` is 1 only from the first falling edge of an output phase until the frame ends, and is 0 during opcode, address and dummy bytes.
- R3: `mode3` equals the SCK level seen when chip select falls (0 gives mode 0, 1 gives mode 3). Both modes give the same results.
- R4: Opcode 03h takes three address bytes, high byte first. It then streams array bytes starting at that address, adding one to the address after each byte.
- R5: Opcode 0Bh behaves like 03h, with one extra dummy byte after the address before data begins.
- R6: Only the low ADDR_W (19) address bits are kept, so bits 23..19 are ignored and 7FFFFh is followed by 00000h. Array location a holds the byte last written with `mem_waddr` equal to a modulo 2^MEM_AW.
- R7: Opcode 05h streams `status_in` bits 7..0 and repeats, taking a fresh copy for each byte. It is accepted even when `status_in[0]` (busy) is 1.
- R8: Opcode ABh takes three bytes, of which only bit 0 of the last one counts. It then alternates 62h and 07h, starting with 62h when that bit is 0 and with 07h when it is 1. When `status_in[0]` is 1 it is rejected: no `cmd_stb`, and SO stays high impedance for the whole frame.
- R9: While the hold is active SO is high impedance and SCK and SI have no effect. After release the stream continues from the bit where it stopped.
- R10: The hold pin is taken into account only while SCK is low. A change made while SCK is high has no effect until SCK goes low.
- R11: A chip-select rise abandons the command, clears the bit and byte counters and the hold, turns SO off and pulses `frame_end` for one cycle.
- R12: Opcodes 01h, 02h, 04h, 06h, B9h, C7h, D8h and FFh pulse `cmd_stb` with the opcode on `cmd_op`. Each later byte of the frame pulses `rx_stb` with its value on `rx_byte`. Address and dummy bytes of reads are reported on `rx_stb` as well.
- R13: Any other opcode is ignored until the next chip-select fall: no strobes and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Hold request, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for SO (0 = high impedance) |
| mode3 | output | 1 | Clock mode captured at the last chip-select fall |
| status_in | input | 8 | Status byte from the controller, bit 0 = busy |
| cmd_stb | output | 1 | One-cycle pulse when an opcode is accepted |
| cmd_op | output | 8 | Last accepted opcode |
| rx_stb | output | 1 | One-cycle pulse for each byte received after the opcode |
| rx_byte | output | 8 | Last received byte |
| frame_end | output | 1 | One-cycle pulse on chip-select rise |
| mem_we | input | 1 | Byte-array write strobe |
| mem_waddr | input | MEM_AW | Byte-array write address |
| mem_wdata | input | 8 | Byte-array write data |

## Verification
A vector table runs each read-type opcode in both clock modes. Array reads near the array end and at 7FFFEh tell correct increment and wrap apart from a stuck or unwrapped address. A start address with bits 23..19 set shows those bits are dropped. Two status values, one with the busy bit set, show that the status path repeats and ignores busy. Starting the ID read from either low-bit value shows which code comes first. Directed frames cover an ID read while busy, an unknown opcode followed by a clean frame, a pass-through write frame, an abort during the address, and a hold held in the middle of an output byte while SCK and SI toggle. The bench also drives the hold pin while SCK is high and ends a frame in the middle of a hold.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [2:0] {
    PH_OPC, PH_ADR, PH_DMY, PH_RX, PH_OUT, PH_IGN
  } phase_t;

  typedef enum logic [1:0] {
    SRC_MEM, SRC_STAT, SRC_ID
  } src_t;

  localparam logic [7:0] OP_RD   = 8'h03;
  localparam logic [7:0] OP_FRD  = 8'h0B;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_ID   = 8'hAB;
  localparam logic [7:0] ID_MFR  = 8'h62;
  localparam logic [7:0] ID_DEV  = 8'h07;

  // opcodes handed to the execution controller unchanged
  function automatic logic fwd_op(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h04, 8'h06, 8'hB9, 8'hC7, 8'hD8, 8'hFF: fwd_op = 1'b1;
      default:                                                 fwd_op = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spf_pins.sv
module spf_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic cs_n_pin,
  input  logic si_pin,
  input  logic hold_n_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_idle,
  output logic cs_stop,
  output logic si_bit,
  output logic holding,
  output logic mode3
);
  logic sck_q, sck_d, cs_q, cs_d, si_q, hldn_q, hold_q, mode_q;
  logic hold_n, mode_n;

  always_comb begin
    hold_n = hold_q;
    if (cs_q)        hold_n = 1'b0;
    else if (!sck_q) hold_n = !hldn_q;
    mode_n = (!cs_q && cs_d) ? sck_q : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sck_d  <= 1'b0;
      cs_q   <= 1'b1;
      cs_d   <= 1'b1;
      si_q   <= 1'b0;
      hldn_q <= 1'b1;
      hold_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      sck_q  <= sck_pin;
      sck_d  <= sck_q;
      cs_q   <= cs_n_pin;
      cs_d   <= cs_q;
      si_q   <= si_pin;
      hldn_q <= hold_n_pin;
      hold_q <= hold_n;
      mode_q <= mode_n;
    end
  end

  assign sck_rise = sck_q && !sck_d && !cs_q && !hold_q;
  assign sck_fall = !sck_q && sck_d && !cs_q && !hold_q;
  assign cs_idle  = cs_q;
  assign cs_stop  = cs_q && !cs_d;
  assign si_bit   = si_q;
  assign holding  = hold_q;
  assign mode3    = mode_q;

  AST_HOLD_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hold_q) && !$past(cs_q)) |-> !$past(sck_q)); // R10
endmodule

// File: rtl/spf_mem.sv
module spf_mem #(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [MEM_AW-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int ADDR_W = 19,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              mode3,
  input  logic [7:0]        status_in,
  output logic              cmd_stb,
  output logic [7:0]        cmd_op,
  output logic              rx_stb,
  output logic [7:0]        rx_byte,
  output logic              frame_end,
  input  logic              mem_we,
  input  logic [MEM_AW-1:0] mem_waddr,
  input  logic [7:0]        mem_wdata
);
  import spf_pkg::*;

  localparam int          ADR_BYTES = 3;
  localparam logic [1:0]  ADR_LAST  = 2'(ADR_BYTES - 1);

  logic sck_rise, sck_fall, cs_idle, si_bit, holding;

  spf_pins u_pins (
    .clk(clk), .rst_n(rst_n),
    .sck_pin(spi_sck), .cs_n_pin(spi_cs_n), .si_pin(spi_si), .hold_n_pin(spi_hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_idle(cs_idle), .cs_stop(frame_end),
    .si_bit(si_bit), .holding(holding), .mode3(mode3)
  );

  phase_t            phase_q, phase_n;
  src_t              src_q, src_n;
  logic              dmy_q, dmy_n;
  logic [6:0]        shin_q, shin_n;
  logic [2:0]        bcnt_q, bcnt_n;
  logic [1:0]        acnt_q, acnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_shift, addr_inc, rd_addr;
  logic [7:0]        obyte_q, obyte_n;
  logic [2:0]        obit_q, obit_n;
  logic              so_q, so_n, live_q, live_n;
  logic              cstb_q, cstb_n, rstb_q, rstb_n;
  logic [7:0]        cop_q, cop_n, rbyte_q, rbyte_n;
  logic [7:0]        byte_in, mem_rdata;
  logic              busy;

  assign byte_in    = {shin_q, si_bit};
  assign busy       = status_in[0];
  assign addr_shift = ADDR_W'({addr_q, byte_in});
  assign addr_inc   = addr_q + 1'b1;

  always_comb begin
    rd_addr = addr_q;
    if (phase_q == PH_ADR)      rd_addr = addr_shift;
    else if (phase_q == PH_OUT) rd_addr = addr_inc;
  end

  spf_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr[MEM_AW-1:0]), .rdata(mem_rdata)
  );

  always_comb begin
    phase_n = phase_q;  src_n  = src_q;   dmy_n   = dmy_q;
    shin_n  = shin_q;   bcnt_n = bcnt_q;  acnt_n  = acnt_q;
    addr_n  = addr_q;   obyte_n = obyte_q; obit_n = obit_q;
    so_n    = so_q;     live_n = live_q;
    cstb_n  = 1'b0;     cop_n  = cop_q;
    rstb_n  = 1'b0;     rbyte_n = rbyte_q;
    if (cs_idle) begin
      phase_n = PH_OPC;
      bcnt_n  = 3'd0;
      acnt_n  = 2'd0;
      live_n  = 1'b0;
    end else begin
      if (sck_rise) begin
        shin_n = byte_in[6:0];
        bcnt_n = bcnt_q + 3'd1;
        if (bcnt_q == 3'd7) begin
          case (phase_q)
            PH_OPC: begin
              if (byte_in == OP_RD || byte_in == OP_FRD) begin
                phase_n = PH_ADR; src_n = SRC_MEM; dmy_n = (byte_in == OP_FRD); cstb_n = 1'b1;
              end else if (byte_in == OP_RDSR) begin
                phase_n = PH_OUT; src_n = SRC_STAT; obyte_n = status_in; obit_n = 3'd7; cstb_n = 1'b1;
              end else if (byte_in == OP_ID && !busy) begin
                phase_n = PH_ADR; src_n = SRC_ID; dmy_n = 1'b0; cstb_n = 1'b1;
              end else if (fwd_op(byte_in)) begin
                phase_n = PH_RX; cstb_n = 1'b1;
              end else begin
                phase_n = PH_IGN;
              end
              if (cstb_n) cop_n = byte_in;
            end
            PH_ADR: begin
              rstb_n  = 1'b1;
              rbyte_n = byte_in;
              addr_n  = addr_shift;
              acnt_n  = acnt_q + 2'd1;
              if (acnt_q == ADR_LAST) begin
                if (dmy_q) begin
                  phase_n = PH_DMY;
                end else begin
                  phase_n = PH_OUT;
                  obit_n  = 3'd7;
                  if (src_q == SRC_ID) obyte_n = byte_in[0] ? ID_DEV : ID_MFR;
                  else                 obyte_n = mem_rdata;
                end
              end
            end
            PH_DMY: begin
              rstb_n  = 1'b1;
              rbyte_n = byte_in;
              phase_n = PH_OUT;
              obit_n  = 3'd7;
              obyte_n = mem_rdata;
            end
            PH_RX: begin
              rstb_n  = 1'b1;
              rbyte_n = byte_in;
            end
            default: ;
          endcase
        end
      end
      if (sck_fall && phase_q == PH_OUT) begin
        so_n   = obyte_q[obit_q];
        live_n = 1'b1;
        if (obit_q == 3'd0) begin
          obit_n = 3'd7;
          case (src_q)
            SRC_MEM:  begin addr_n = addr_inc; obyte_n = mem_rdata; end
            SRC_STAT: obyte_n = status_in;
            default:  obyte_n = (obyte_q == ID_MFR) ? ID_DEV : ID_MFR;
          endcase
        end else begin
          obit_n = obit_q - 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC;  src_q  <= SRC_MEM; dmy_q   <= 1'b0;
      shin_q  <= '0;      bcnt_q <= '0;      acnt_q  <= '0;
      addr_q  <= '0;      obyte_q <= '0;     obit_q  <= 3'd7;
      so_q    <= 1'b0;    live_q <= 1'b0;
      cstb_q  <= 1'b0;    cop_q  <= '0;
      rstb_q  <= 1'b0;    rbyte_q <= '0;
    end else begin
      phase_q <= phase_n; src_q  <= src_n;   dmy_q   <= dmy_n;
      shin_q  <= shin_n;  bcnt_q <= bcnt_n;  acnt_q  <= acnt_n;
      addr_q  <= addr_n;  obyte_q <= obyte_n; obit_q <= obit_n;
      so_q    <= so_n;    live_q <= live_n;
      cstb_q  <= cstb_n;  cop_q  <= cop_n;
      rstb_q  <= rstb_n;  rbyte_q <= rbyte_n;
    end
  end

  assign spi_so    = so_q;
  assign spi_so_oe = live_q && !holding && !cs_idle;
  assign cmd_stb   = cstb_q;
  assign cmd_op    = cop_q;
  assign rx_stb    = rstb_q;
  assign rx_byte   = rbyte_q;

  AST_OE_ONLY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    spi_so_oe |-> phase_q == PH_OUT); // R2
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !cs_idle) |=> ($stable(bcnt_q) && $stable(obit_q))); // R9
  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (phase_q == PH_OPC && bcnt_q == 3'd0 && !spi_so_oe)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && rx_stb)); // R12
  AST_ID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_op == OP_ID) |-> !$past(status_in[0])); // R8
  AST_IGNORED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IGN) |=> (!cmd_stb && !rx_stb)); // R13
endmodule

// File: tb/sim_spi_flash_front.sv
module sim_spi_flash_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, mode3, cmd_stb, rx_stb, frame_end;
  logic [7:0] status_in = 8'h00, cmd_op, rx_byte;
  logic mem_we = 1'b0;
  logic [5:0] mem_waddr = '0;
  logic [7:0] mem_wdata = '0;

  int total = 0, bad = 0;
  int n_cmd = 0, n_rx = 0, n_end = 0;
  logic [7:0] last_op = '0, last_rx = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_flash_front u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .mode3(mode3),
    .status_in(status_in), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .rx_stb(rx_stb),
    .rx_byte(rx_byte), .frame_end(frame_end), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (cmd_stb)   begin n_cmd++; last_op = cmd_op; end
    if (rx_stb)    begin n_rx++;  last_rx = rx_byte; end
    if (frame_end) n_end++;
  end

  // vector: {mode3, opcode, 24-bit address, status}
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 8'h03, 24'h000010, 8'h00},
    {1'b1, 8'h03, 24'h00003E, 8'h00},
    {1'b0, 8'h0B, 24'h07FFFE, 8'h00},
    {1'b1, 8'h0B, 24'hF80005, 8'h00},
    {1'b0, 8'h05, 24'h000000, 8'hA5},
    {1'b1, 8'h05, 24'h000000, 8'h3C},
    {1'b0, 8'hAB, 24'h000000, 8'h00},
    {1'b1, 8'hAB, 24'h000001, 8'h00}
  };

  function automatic logic [7:0] fmem(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] model(input logic [7:0] op, input logic [23:0] a,
                                       input logic [7:0] st, input int k);
    if (op == 8'h05) return st;
    if (op == 8'hAB) return (a[0] ^ k[0]) ? 8'h07 : 8'h62;
    return fmem(int'((a[18:0] + 19'(k)) & 19'h3F));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w4();
    repeat (4) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic o, output logic e);
    sck = 1'b0; si = b; w4();
    o = so; e = so_oe;
    sck = 1'b1; w4();
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any);
    logic o, e;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sbit(tx[i], o, e);
      rx[i] = o; oe_all &= e; oe_any |= e;
    end
  endtask

  task automatic begin_frame(input logic m3);
    sck = m3; w4();
    cs_n = 1'b0; w4();
  endtask

  task automatic end_frame(input logic m3);
    if (!m3) begin sck = 1'b0; w4(); end
    cs_n = 1'b1; w4(); w4();
  endtask

  initial begin
    logic [7:0] rx, b;
    logic oa, on, o, e;
    logic [40:0] v;
    int c0, r0, e0;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
    chk(mode3 == 1'b0, "R1 mode3", mode3, 0);
    chk(n_cmd == 0 && n_rx == 0, "R1 strobes", n_cmd + n_rx, 0);
    // load array: location a holds fmem(a)
    for (int a = 0; a < 64; a++) begin
      mem_we = 1'b1; mem_waddr = 6'(a); mem_wdata = fmem(a);
      @(negedge clk);
    end
    mem_we = 1'b0;

    // table of read-type frames
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      status_in = v[7:0];
      case (v[39:32])
        8'h03:   tag = "R4 R6";
        8'h0B:   tag = "R5 R6";
        8'h05:   tag = "R7";
        default: tag = "R8";
      endcase
      begin_frame(v[40]);
      chk(mode3 == v[40], "R3 mode", mode3, v[40]);
      xfer(v[39:32], rx, oa, on);
      chk(!on, "R2 oe during opcode", on, 0);
      if (v[39:32] != 8'h05) begin
        for (int k = 2; k >= 0; k--) begin
          xfer(v[8 + 8*k +: 8], rx, oa, on);
          chk(!on, "R2 oe during address", on, 0);
        end
        if (v[39:32] == 8'h0B) begin
          xfer(8'hC3, rx, oa, on);
          chk(!on, "R5 oe during dummy", on, 0);
        end
      end
      for (int k = 0; k < 3; k++) begin
        xfer(8'h00, rx, oa, on);
        chk(rx == model(v[39:32], v[31:8], v[7:0], k), tag, rx,
            model(v[39:32], v[31:8], v[7:0], k));
        chk(oa, "R2 oe during output", oa, 1);
      end
      end_frame(v[40]);
      chk(!so_oe, "R11 oe after frame", so_oe, 0);
    end

    // R8: ID read rejected while busy
    status_in = 8'h01; c0 = n_cmd;
    begin_frame(1'b0);
    xfer(8'hAB, rx, oa, on);
    for (int k = 0; k < 4; k++) xfer(8'h00, rx, oa, on);
    chk(!on, "R8 busy id no output", on, 0);
    chk(n_cmd == c0, "R8 busy id no cmd", n_cmd, c0);
    end_frame(1'b0);

    // R13: unknown opcode, then a clean status frame
    status_in = 8'h5A; c0 = n_cmd; r0 = n_rx;
    begin_frame(1'b0);
    xfer(8'h5A, rx, oa, on);
    for (int k = 0; k < 3; k++) xfer(8'h12, rx, oa, on);
    chk(!on, "R13 no output", on, 0);
    chk(n_cmd == c0 && n_rx == r0, "R13 no strobes", n_cmd + n_rx, c0 + r0);
    end_frame(1'b0);
    begin_frame(1'b1);
    xfer(8'h05, rx, oa, on);
    xfer(8'h00, rx, oa, on);
    chk(rx == 8'h5A, "R13 next frame decodes", rx, 8'h5A);
    end_frame(1'b1);

    // R12: pass-through page write frame
    status_in = 8'h00; c0 = n_cmd; r0 = n_rx; e0 = n_end;
    begin_frame(1'b0);
    xfer(8'h02, rx, oa, on);
    xfer(8'h00, rx, oa, on); xfer(8'h01, rx, oa, on); xfer(8'h02, rx, oa, on);
    xfer(8'hAA, rx, oa, on); xfer(8'h55, rx, oa, on);
    end_frame(1'b0);
    chk(n_cmd == c0 + 1 && last_op == 8'h02, "R12 opcode strobe", last_op, 8'h02);
    chk(n_rx == r0 + 5, "R12 byte count", n_rx - r0, 5);
    chk(last_rx == 8'h55, "R12 last byte", last_rx, 8'h55);
    chk(n_end == e0 + 1, "R11 frame_end pulse", n_end - e0, 1);

    // R11: abort during address, then status frame
    status_in = 8'hC3;
    begin_frame(1'b0);
    xfer(8'h03, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'h00, rx, oa, on);
    end_frame(1'b0);
    begin_frame(1'b0);
    xfer(8'h05, rx, oa, on);
    xfer(8'h00, rx, oa, on);
    chk(rx == 8'hC3 && oa, "R11 abort then status", rx, 8'hC3);
    end_frame(1'b0);

    // R9 / R10: hold in the middle of an output byte
    begin_frame(1'b0);
    xfer(8'h03, rx, oa, on);
    xfer(8'h00, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'h05, rx, oa, on);
    xfer(8'h00, rx, oa, on);
    chk(rx == fmem(5), "R4 first byte before hold", rx, fmem(5));
    for (int i = 7; i >= 5; i--) begin sbit(1'b0, o, e); b[i] = o; end
    hold_n = 1'b0; w4();
    chk(so_oe == 1'b1, "R10 hold ignored while sck high", so_oe, 1);
    hold_n = 1'b1; w4();
    sck = 1'b0; w4(); b[4] = so;
    hold_n = 1'b0; w4();
    chk(so_oe == 1'b0, "R9 so off in hold", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1'b1; w4(); sck = 1'b0; w4();
    end
    hold_n = 1'b1; w4();
    chk(so_oe == 1'b1 && so == b[4], "R9 resume after hold", so, b[4]);
    sck = 1'b1; w4();
    for (int i = 3; i >= 0; i--) begin sbit(1'b0, o, e); b[i] = o; end
    chk(b == fmem(6), "R9 byte across hold", b, fmem(6));
    end_frame(1'b0);

    // R11: chip select rises during a hold
    status_in = 8'h99;
    begin_frame(1'b0);
    xfer(8'h05, rx, oa, on);
    sck = 1'b0; w4();
    hold_n = 1'b0; w4();
    cs_n = 1'b1; w4();
    chk(so_oe == 1'b0, "R11 off after cs in hold", so_oe, 0);
    hold_n = 1'b1; w4();
    begin_frame(1'b0);
    xfer(8'h05, rx, oa, on);
    xfer(8'h00, rx, oa, on);
    chk(rx == 8'h99 && oa, "R11 hold released by cs", rx, 8'h99);
    end_frame(1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule